// File: doc/BRIEF.md
# HDLC Receive Frame Length Guard

This block sits after an HDLC deframer and enforces a programmable ceiling on the size of each received frame. The deframer marks the opening flag with a one-cycle start pulse, strobes each in-frame data byte, and closes the frame with either an end pulse or an error/abort pulse. At each opening flag the guard captures a 16-bit limit and loads a down-counter from it. The counter is decremented for every in-frame byte.

Bytes that fit within the limit are forwarded downstream one cycle later, unchanged. Once the limit is used up, later bytes of that frame are dropped without notice. The frame is still closed out normally. On the closing event the guard emits a single report carrying the frame length, an overlength flag and an error flag. An overlength frame reports a length of limit plus one. The next opening flag reloads the counter, so one frame never affects the next.

Top module: `hdlc_frame_len_guard`

## Requirements
- R1: While `rst` is high and in the first cycle after it, `out_vld_o` and `rpt_vld_o` are 0, and the guard is idle (not inside a frame).
- R2: The reported length equals the number of `byte_vld_i` strobes accepted between the opening start pulse and the closing event. The start and closing pulses themselves are not counted.
- R3: A byte accepted while fewer than `limit` bytes of the current frame have been seen appears on `out_byte_o` with `out_vld_o`=1 exactly one cycle later, with its value unchanged.
- R4: Once `limit` bytes of a frame have been accepted, every later byte of that frame is dropped: `out_vld_o` stays 0 in the cycle after it.
- R5: If any byte of a frame was dropped, the report has `rpt_long_o`=1 and `rpt_len_o` = limit+1. Otherwise `rpt_long_o`=0.
- R6: A pulse on `eof_i` inside a frame produces exactly one report: `rpt_vld_o`=1 for one cycle, one cycle after the pulse, with `rpt_err_o`=0. The guard then returns to idle.
- R7: A pulse on `err_i` inside a frame closes it with exactly one report one cycle later, with `rpt_err_o`=1, and the guard returns to idle.
- R8: The counter reloads at every opening start pulse, so a frame that follows an overlength frame is measured from zero against its own limit.
- R9: `limit_i` is sampled only at the opening start pulse. Changing it during a frame has no effect on that frame.
- R10: While idle, `byte_vld_i`, `eof_i` and `err_i` are ignored: no byte is forwarded and no report is produced.
- R11: A `sof_i` pulse inside a frame is ignored. Counting continues and the limit is not reloaded.
- R12: A byte strobed in the same cycle as the closing pulse counts as the last byte of the frame. It is forwarded or dropped by the normal rule and included in the reported length.
- R13: With a limit of 0, every byte of the frame is dropped. An empty frame reports length 0 with `rpt_long_o`=0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sof_i | input | 1 | Opening-flag pulse from the deframer |
| byte_vld_i | input | 1 | In-frame data byte strobe |
| byte_i | input | 8 | Data byte |
| eof_i | input | 1 | Closing-flag pulse |
| err_i | input | 1 | Abort or error pulse; closes the frame |
| limit_i | input | 16 | Maximum frame length, sampled at the opening pulse |
| out_vld_o | output | 1 | Forwarded byte valid |
| out_byte_o | output | 8 | Forwarded byte |
| rpt_vld_o | output | 1 | Frame report valid, one cycle per frame |
| rpt_len_o | output | 17 | Frame length, saturated at limit+1 |
| rpt_long_o | output | 1 | Overlength flag |
| rpt_err_o | output | 1 | Frame closed by error/abort |

## Verification
Every result of this block is due exactly one register stage after its stimulus. A forwarded byte appears in the cycle after its strobe. A report appears in the cycle after the end or error pulse, and it includes any byte strobed alongside that pulse. The bench drives inputs just after the falling edge. A behavioural model updates its expected outputs at each rising edge from the inputs held across that edge, and the design's outputs are compared against it at the following falling edge, so every comparison lands one cycle after its cause. Each scenario carries the tag of the requirement it exercises, and any mismatch is reported under that tag.

// File: rtl/hfl_pkg.sv
package hfl_pkg;

    localparam int LIM_W_DEF  = 16;
    localparam int DATA_W_DEF = 8;

    typedef enum logic {
        FS_IDLE  = 1'b0,
        FS_FRAME = 1'b1
    } fstate_e;

    typedef struct packed {
        logic long_f;
        logic err_f;
    } rpt_flags_t;

    typedef struct packed {
        logic open_f;
        logic take_f;
        logic close_f;
    } frame_evt_t;

endpackage

// File: rtl/hfl_frame_ctl.sv
module hfl_frame_ctl
    import hfl_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       sof_i,
    input  logic       byte_vld_i,
    input  logic       eof_i,
    input  logic       err_i,
    output frame_evt_t evt_o,
    output logic       in_frame_o
);

    fstate_e state_q;
    fstate_e state_d;

    always_comb begin
        evt_o   = '0;
        state_d = state_q;
        case (state_q)
            FS_IDLE: begin
                if (sof_i) begin
                    evt_o.open_f = 1'b1;
                    state_d      = FS_FRAME;
                end
            end
            FS_FRAME: begin
                evt_o.take_f  = byte_vld_i;
                evt_o.close_f = eof_i | err_i;
                if (eof_i | err_i) begin
                    state_d = FS_IDLE;
                end
            end
            default: state_d = FS_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= FS_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    assign in_frame_o = (state_q == FS_FRAME);

endmodule

// File: rtl/hfl_len_track.sv
module hfl_len_track #(
    parameter int LIM_W = 16,
    parameter int LEN_W = LIM_W + 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             open_i,
    input  logic             take_i,
    input  logic [LIM_W-1:0] lim_i,
    output logic             room_o,
    output logic             long_q_o,
    output logic [LIM_W-1:0] lim_q_o,
    output logic [LEN_W-1:0] len_nxt_o,
    output logic             long_nxt_o
);

    logic [LIM_W-1:0] rem_q;
    logic [LIM_W-1:0] rem_nxt;
    logic             long_q;
    logic [LIM_W-1:0] lim_q;

    assign room_o = (rem_q != '0);

    always_comb begin
        rem_nxt    = rem_q;
        long_nxt_o = long_q;
        if (take_i) begin
            if (room_o) begin
                rem_nxt = rem_q - LIM_W'(1);
            end else begin
                long_nxt_o = 1'b1;
            end
        end
        if (long_nxt_o) begin
            len_nxt_o = LEN_W'(lim_q) + LEN_W'(1);
        end else begin
            len_nxt_o = LEN_W'(lim_q - rem_nxt);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rem_q  <= '0;
            lim_q  <= '0;
            long_q <= 1'b0;
        end else if (open_i) begin
            rem_q  <= lim_i;
            lim_q  <= lim_i;
            long_q <= 1'b0;
        end else begin
            rem_q  <= rem_nxt;
            long_q <= long_nxt_o;
        end
    end

    assign long_q_o = long_q;
    assign lim_q_o  = lim_q;

endmodule

// File: rtl/hfl_byte_gate.sv
module hfl_byte_gate #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              take_i,
    input  logic              room_i,
    input  logic [DATA_W-1:0] byte_i,
    output logic              vld_o,
    output logic [DATA_W-1:0] byte_o
);

    always_ff @(posedge clk) begin
        if (rst) begin
            vld_o  <= 1'b0;
            byte_o <= '0;
        end else begin
            vld_o <= take_i & room_i;
            if (take_i & room_i) begin
                byte_o <= byte_i;
            end
        end
    end

endmodule

// File: rtl/hfl_report.sv
module hfl_report
    import hfl_pkg::*;
#(
    parameter int LEN_W = 17
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             close_i,
    input  logic [LEN_W-1:0] len_i,
    input  rpt_flags_t       flags_i,
    output logic             vld_o,
    output logic [LEN_W-1:0] len_o,
    output rpt_flags_t       flags_o
);

    always_ff @(posedge clk) begin
        if (rst) begin
            vld_o   <= 1'b0;
            len_o   <= '0;
            flags_o <= '0;
        end else begin
            vld_o <= close_i;
            if (close_i) begin
                len_o   <= len_i;
                flags_o <= flags_i;
            end
        end
    end

endmodule

// File: rtl/hdlc_frame_len_guard.sv
module hdlc_frame_len_guard
    import hfl_pkg::*;
#(
    parameter int LIM_W  = LIM_W_DEF,
    parameter int DATA_W = DATA_W_DEF,
    localparam int LEN_W = LIM_W + 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              sof_i,
    input  logic              byte_vld_i,
    input  logic [DATA_W-1:0] byte_i,
    input  logic              eof_i,
    input  logic              err_i,
    input  logic [LIM_W-1:0]  limit_i,
    output logic              out_vld_o,
    output logic [DATA_W-1:0] out_byte_o,
    output logic              rpt_vld_o,
    output logic [LEN_W-1:0]  rpt_len_o,
    output logic              rpt_long_o,
    output logic              rpt_err_o
);

    frame_evt_t       evt;
    logic             in_frame;
    logic             room;
    logic             long_q;
    logic [LIM_W-1:0] lim_q;
    logic [LEN_W-1:0] len_nxt;
    logic             long_nxt;
    rpt_flags_t       flags_in;
    rpt_flags_t       flags_out;

    hfl_frame_ctl u_ctl (
        .clk        (clk),
        .rst        (rst),
        .sof_i      (sof_i),
        .byte_vld_i (byte_vld_i),
        .eof_i      (eof_i),
        .err_i      (err_i),
        .evt_o      (evt),
        .in_frame_o (in_frame)
    );

    hfl_len_track #(.LIM_W(LIM_W), .LEN_W(LEN_W)) u_len (
        .clk        (clk),
        .rst        (rst),
        .open_i     (evt.open_f),
        .take_i     (evt.take_f),
        .lim_i      (limit_i),
        .room_o     (room),
        .long_q_o   (long_q),
        .lim_q_o    (lim_q),
        .len_nxt_o  (len_nxt),
        .long_nxt_o (long_nxt)
    );

    hfl_byte_gate #(.DATA_W(DATA_W)) u_gate (
        .clk    (clk),
        .rst    (rst),
        .take_i (evt.take_f),
        .room_i (room),
        .byte_i (byte_i),
        .vld_o  (out_vld_o),
        .byte_o (out_byte_o)
    );

    always_comb begin
        flags_in.long_f = long_nxt;
        flags_in.err_f  = err_i;
    end

    hfl_report #(.LEN_W(LEN_W)) u_rpt (
        .clk     (clk),
        .rst     (rst),
        .close_i (evt.close_f),
        .len_i   (len_nxt),
        .flags_i (flags_in),
        .vld_o   (rpt_vld_o),
        .len_o   (rpt_len_o),
        .flags_o (flags_out)
    );

    assign rpt_long_o = flags_out.long_f;
    assign rpt_err_o  = flags_out.err_f;

endmodule

// File: rtl/hfl_guard_chk.sv
module hfl_guard_chk #(
    parameter int LIM_W = 16,
    parameter int LEN_W = LIM_W + 1
) (
    input logic             clk,
    input logic             rst,
    input logic             byte_vld_i,
    input logic             eof_i,
    input logic             err_i,
    input logic             out_vld_o,
    input logic             rpt_vld_o,
    input logic [LEN_W-1:0] rpt_len_o,
    input logic             rpt_long_o,
    input logic             in_frame,
    input logic             long_q,
    input logic [LIM_W-1:0] lim_q
);

    p_pass_needs_byte_r3: assert property (@(posedge clk) disable iff (rst)
        out_vld_o |-> $past(byte_vld_i));

    p_drop_after_long_r4: assert property (@(posedge clk) disable iff (rst)
        (in_frame && long_q && byte_vld_i) |=> !out_vld_o);

    p_long_len_r5: assert property (@(posedge clk) disable iff (rst)
        (rpt_vld_o && rpt_long_o) |-> (rpt_len_o == LEN_W'(lim_q) + LEN_W'(1)));

    p_short_len_r2: assert property (@(posedge clk) disable iff (rst)
        (rpt_vld_o && !rpt_long_o) |-> (rpt_len_o <= LEN_W'(lim_q)));

    p_rpt_needs_close_r6: assert property (@(posedge clk) disable iff (rst)
        rpt_vld_o |-> $past(eof_i || err_i));

    p_idle_quiet_r10: assert property (@(posedge clk) disable iff (rst)
        !in_frame |=> (!out_vld_o && !rpt_vld_o));

endmodule

bind hdlc_frame_len_guard hfl_guard_chk #(.LIM_W(LIM_W), .LEN_W(LEN_W)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .byte_vld_i (byte_vld_i),
    .eof_i      (eof_i),
    .err_i      (err_i),
    .out_vld_o  (out_vld_o),
    .rpt_vld_o  (rpt_vld_o),
    .rpt_len_o  (rpt_len_o),
    .rpt_long_o (rpt_long_o),
    .in_frame   (in_frame),
    .long_q     (long_q),
    .lim_q      (lim_q)
);

// File: tb/hdlc_frame_len_guard_test.sv
`timescale 1ns/1ps
module hdlc_frame_len_guard_test;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        sof_i = 1'b0;
    logic        byte_vld_i = 1'b0;
    logic [7:0]  byte_i = '0;
    logic        eof_i = 1'b0;
    logic        err_i = 1'b0;
    logic [15:0] limit_i = '0;
    logic        out_vld_o;
    logic [7:0]  out_byte_o;
    logic        rpt_vld_o;
    logic [16:0] rpt_len_o;
    logic        rpt_long_o;
    logic        rpt_err_o;

    int    n_checks = 0;
    int    n_fail = 0;
    string cur_req = "R1";
    logic  done = 1'b0;

    // model state
    bit m_in = 0;
    int m_rem = 0;
    int m_lim = 0;
    bit m_long = 0;
    bit e_ov = 0;
    int e_ob = 0;
    bit e_rv = 0;
    int e_len = 0;
    bit e_lg = 0;
    bit e_er = 0;
    int n_rpt_exp = 0;
    int n_rpt_seen = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    hdlc_frame_len_guard uut (
        .clk        (clk),
        .rst        (rst),
        .sof_i      (sof_i),
        .byte_vld_i (byte_vld_i),
        .byte_i     (byte_i),
        .eof_i      (eof_i),
        .err_i      (err_i),
        .limit_i    (limit_i),
        .out_vld_o  (out_vld_o),
        .out_byte_o (out_byte_o),
        .rpt_vld_o  (rpt_vld_o),
        .rpt_len_o  (rpt_len_o),
        .rpt_long_o (rpt_long_o),
        .rpt_err_o  (rpt_err_o)
    );

    // behavioural reference, advanced at each rising edge
    always @(posedge clk) begin
        e_ov = 0;
        e_rv = 0;
        if (rst) begin
            m_in = 0;
            m_long = 0;
        end else if (!m_in) begin
            if (sof_i) begin
                m_in = 1;
                m_lim = int'(limit_i);
                m_rem = int'(limit_i);
                m_long = 0;
            end
        end else begin
            if (byte_vld_i) begin
                if (m_rem > 0) begin
                    e_ov = 1;
                    e_ob = int'(byte_i);
                    m_rem = m_rem - 1;
                end else begin
                    m_long = 1;
                end
            end
            if (eof_i || err_i) begin
                e_rv = 1;
                e_len = m_long ? m_lim + 1 : m_lim - m_rem;
                e_lg = m_long;
                e_er = err_i;
                m_in = 0;
                n_rpt_exp++;
            end
        end
    end

    task automatic check(input string req, input string what, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s actual=%0d expected=%0d at %0t", req, what, act, exp, $time);
        end
    endtask

    // compare one cycle after each stimulus, away from the rising edge
    always @(negedge clk) begin
        if (!done) begin
            check(cur_req, "out_vld", int'(out_vld_o), int'(e_ov));
            if (e_ov && out_vld_o) check(cur_req, "out_byte", int'(out_byte_o), e_ob);
            check(cur_req, "rpt_vld", int'(rpt_vld_o), int'(e_rv));
            if (rpt_vld_o) n_rpt_seen++;
            if (e_rv && rpt_vld_o) begin
                check(cur_req, "rpt_len", int'(rpt_len_o), e_len);
                check(cur_req, "rpt_long", int'(rpt_long_o), int'(e_lg));
                check(cur_req, "rpt_err", int'(rpt_err_o), int'(e_er));
            end
        end
    end

    task automatic step();
        @(negedge clk);
        #1;
        sof_i = 0; byte_vld_i = 0; eof_i = 0; err_i = 0;
    endtask

    // opening pulse, nb bytes, then a closing pulse; kind 0=eof 1=err;
    // last_with_close puts the final byte in the closing cycle
    task automatic frame(input int lim, input int nb, input int kind, input bit last_with_close);
        step();
        sof_i = 1;
        limit_i = 16'(lim);
        for (int i = 0; i < nb; i++) begin
            if (!(last_with_close && i == nb - 1)) begin
                step();
                byte_vld_i = 1;
                byte_i = 8'(8'h30 + i * 7);
            end
        end
        step();
        if (last_with_close && nb > 0) begin
            byte_vld_i = 1;
            byte_i = 8'hC5;
        end
        if (kind == 1) err_i = 1; else eof_i = 1;
        step();
        step();
    endtask

    initial begin
        // R1: reset state
        cur_req = "R1";
        repeat (3) step();
        rst = 0;
        step();
        check("R1", "out_vld after reset", int'(out_vld_o), 0);
        check("R1", "rpt_vld after reset", int'(rpt_vld_o), 0);

        // R10: activity while idle is ignored
        cur_req = "R10";
        step(); byte_vld_i = 1; byte_i = 8'h11;
        step(); eof_i = 1;
        step(); err_i = 1; byte_vld_i = 1;
        step(); step();

        // R2, R3, R6: short frame
        cur_req = "R2";
        frame(5, 3, 0, 0);
        cur_req = "R3";
        frame(5, 5, 0, 0);
        cur_req = "R6";
        frame(8, 1, 0, 0);

        // R4, R5: overlength frame
        cur_req = "R4";
        frame(4, 7, 0, 0);
        cur_req = "R5";
        frame(2, 9, 0, 0);

        // R8: following frame unaffected
        cur_req = "R8";
        frame(4, 2, 0, 0);

        // R7: error closes frame
        cur_req = "R7";
        frame(10, 3, 1, 0);
        frame(2, 5, 1, 0);

        // R9: limit change mid-frame
        cur_req = "R9";
        step(); sof_i = 1; limit_i = 16'd3;
        step(); byte_vld_i = 1; byte_i = 8'hA1; limit_i = 16'd100;
        for (int i = 0; i < 4; i++) begin
            step(); byte_vld_i = 1; byte_i = 8'(8'hB0 + i);
        end
        step(); eof_i = 1;
        step(); step();

        // R11: second opening pulse inside a frame
        cur_req = "R11";
        step(); sof_i = 1; limit_i = 16'd3;
        step(); byte_vld_i = 1; byte_i = 8'h21;
        step(); byte_vld_i = 1; byte_i = 8'h22;
        step(); sof_i = 1; limit_i = 16'd50;
        step(); byte_vld_i = 1; byte_i = 8'h23;
        step(); byte_vld_i = 1; byte_i = 8'h24;
        step(); eof_i = 1;
        step(); step();

        // R12: byte together with closing pulse
        cur_req = "R12";
        frame(3, 3, 0, 1);
        frame(3, 4, 0, 1);
        frame(6, 2, 1, 1);

        // R13: zero limit
        cur_req = "R13";
        frame(0, 0, 0, 0);
        frame(0, 2, 0, 0);

        step(); step();
        check("R6", "one report per closed frame", n_rpt_seen, n_rpt_exp);
        done = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_checks++;
            n_fail++;
            $display("FAIL %s watchdog expired actual=running expected=done", cur_req);
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

endmodule